// File: doc/BRIEF.md
# Dual-Mode Multiplexed Host Bus Slave

This block connects a small internal register file to a host processor over an 8-bit bus that carries both the address and the data. The host strobes (address strobe, data strobe, read/write and an active-low chip select) are asynchronous. Each one passes through a two-flop synchronizer into the local clock domain, and all edge detection happens after the synchronizer. When the address strobe falls, the block latches the bus as the register address. It also records whether the access is selected and which of two handshake styles the access uses.

The handshake style is chosen separately for every access, from the data-strobe level seen when the address strobe falls:

- **Style A (data strobe high at that edge):** a low data strobe with read/write high opens a read, and a low pulse on read/write performs a write.
- **Style B (data strobe low at that edge):** read/write sets the direction, and a high pulse on the data strobe either opens the read drivers or strobes the write data.

A write is committed on the trailing edge of its strobe. It updates the register file and raises a single-cycle write pulse carrying the address and the data. Reads present the addressed register on a separate output bus, together with an enable for an external bidirectional pad.

Top module: `hostMuxBus`

## Requirements
- R1: After reset the pad enable and the write pulse are low and every register reads as 0.
- R2: The bus value present when the address strobe falls is latched as the register address for that access.
- R3: An access whose chip select was high at the address-strobe fall produces no write pulse and never raises the pad enable.
- R4: In style A, the pad enable is high while the data strobe is low and read/write is 1, and the read bus then carries the addressed register.
- R5: In style A, a write commits on the rising (trailing) edge of a low read/write pulse, with the bus value present at that edge.
- R6: In style B, the pad enable is high while the data strobe is high and read/write is 1, and the read bus then carries the addressed register.
- R7: In style B, with read/write at 0, a write commits on the falling (trailing) edge of a high data-strobe pulse.
- R8: An access produces at most one write pulse, and that pulse lasts one clock. Further strobes in the same access are ignored, and the register keeps the first value written.
- R9: The pad enable is low throughout the address phase (address strobe high) and whenever the access is not selected.
- R10: Addresses at or above DEPTH (4 by default) are unmapped. A write to one produces no pulse and changes no register, and a read of one drives 0 with the pad enable high.
- R11: The handshake style is chosen anew on every access, so consecutive accesses may alternate between style A and style B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adIn | input | 8 | Bus value seen from the pad (address or write data) |
| adOut | output | 8 | Read data toward the pad |
| adOe | output | 1 | Pad output enable |
| asIn | input | 1 | Address strobe; a falling edge latches the address |
| dsIn | input | 1 | Data strobe |
| rwIn | input | 1 | Read/write, 1 = read |
| csN | input | 1 | Chip select, active low, sampled at the address-strobe fall |
| wrPulse | output | 1 | Single-cycle register write strobe |
| wrAddr | output | 8 | Address of the access |
| wrData | output | 8 | Data committed by the last write |

## Verification
The bench uses the default DEPTH of 4 with an 8-bit bus. With that setting, random addresses drawn from 0 to 7 land on mapped and unmapped locations about equally often, which exercises the dropped writes and zero reads of R10. Random accesses choose the handshake style, the chip select and the direction independently, so style switches between back-to-back accesses (R11) occur many times. A reference copy of the four registers predicts every read value and every write pulse.

// File: rtl/hostMuxBusPkg.sv
package hostMuxBusPkg;
  // strobes issued by the control unit to the datapath
  typedef struct packed {
    logic capAddr;   // latch the bus as address
    logic commit;    // write the bus into the addressed register
  } hmbStrobe_t;
endpackage

// File: rtl/hmbSync.sv
module hmbSync #(
  parameter int N = 4,
  parameter logic [N-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] rawIn,
  output logic [N-1:0] syncOut
);
  for (genvar g = 0; g < N; g++) begin : gBit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= IDLE[g];
        stage2 <= IDLE[g];
      end else begin
        stage1 <= rawIn[g];
        stage2 <= stage1;
      end
    end
    assign syncOut[g] = stage2;
  end
endmodule

// File: rtl/hmbCtrl.sv
module hmbCtrl
  import hostMuxBusPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       asS,
  input  logic       dsS,
  input  logic       rwS,
  input  logic       csS,
  input  logic       addrHit,
  output hmbStrobe_t stb,
  output logic       oeQ,
  output logic       selQ
);
  logic asPrev, dsPrev, rwPrev;
  logic styleAQ, doneQ;
  logic asFall, asRise, dsFall, rwRise;
  logic wrStyleA, wrStyleB, oeNext;

  assign asFall = asPrev & ~asS;
  assign asRise = ~asPrev & asS;
  assign dsFall = dsPrev & ~dsS;
  assign rwRise = ~rwPrev & rwS;

  assign wrStyleA = styleAQ & rwRise & ~asS;
  assign wrStyleB = ~styleAQ & dsFall & ~rwS & ~asS;

  always_comb begin
    stb = '0;
    stb.capAddr = asFall;
    stb.commit  = selQ & ~doneQ & addrHit & (wrStyleA | wrStyleB);
  end

  assign oeNext = selQ & ~asS & rwS & (styleAQ ? ~dsS : dsS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asPrev  <= 1'b1;
      dsPrev  <= 1'b1;
      rwPrev  <= 1'b1;
      selQ    <= 1'b0;
      styleAQ <= 1'b1;
      doneQ   <= 1'b0;
      oeQ     <= 1'b0;
    end else begin
      asPrev <= asS;
      dsPrev <= dsS;
      rwPrev <= rwS;
      oeQ    <= oeNext;
      if (asFall) begin
        selQ    <= ~csS;
        styleAQ <= dsS;
        doneQ   <= 1'b0;
      end else begin
        if (asRise) selQ <= 1'b0;
        if (stb.commit) doneQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hmbDatapath.sv
module hmbDatapath
  import hostMuxBusPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  input  hmbStrobe_t        stb,
  output logic              addrHit,
  output logic [DATA_W-1:0] readData,
  output logic              wrPulse,
  output logic [DATA_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DATA_W-1:0] DEPTH_V = DATA_W'(DEPTH);

  logic [DATA_W-1:0] addrQ;
  logic [DATA_W-1:0] regs [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx      = addrQ[IDX_W-1:0];
  assign addrHit  = addrQ < DEPTH_V;
  assign readData = addrHit ? regs[idx] : '0;
  assign wrAddr   = addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrPulse <= 1'b0;
      wrData  <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      wrPulse <= stb.commit;
      if (stb.capAddr) addrQ <= busIn;
      if (stb.commit) begin
        wrData    <= busIn;
        regs[idx] <= busIn;
      end
    end
  end
endmodule

// File: rtl/hostMuxBus.sv
module hostMuxBus
  import hostMuxBusPkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] adIn,
  output logic [7:0] adOut,
  output logic       adOe,
  input  logic       asIn,
  input  logic       dsIn,
  input  logic       rwIn,
  input  logic       csN,
  output logic       wrPulse,
  output logic [7:0] wrAddr,
  output logic [7:0] wrData
);
  logic [3:0] syncV;
  logic asS, dsS, rwS, csS, addrHit, selQ;
  hmbStrobe_t stb;

  hmbSync #(.N(4), .IDLE(4'b1111)) uSync (
    .clk(clk), .rstN(rstN),
    .rawIn({csN, rwIn, dsIn, asIn}), .syncOut(syncV)
  );
  assign {csS, rwS, dsS, asS} = syncV;

  hmbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .asS(asS), .dsS(dsS), .rwS(rwS), .csS(csS),
    .addrHit(addrHit), .stb(stb), .oeQ(adOe), .selQ(selQ)
  );

  hmbDatapath #(.DATA_W(8), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .busIn(adIn), .stb(stb), .addrHit(addrHit),
    .readData(adOut), .wrPulse(wrPulse), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/hostMuxBusChk.sv
module hostMuxBusChk #(
  parameter int DEPTH = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       adOe,
  input logic       wrPulse,
  input logic [7:0] wrAddr,
  input logic       selQ,
  input logic       asS
);
  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);
  // R9
  addr_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    asS |=> !adOe);
  // R9
  unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selQ |=> !adOe);
  // R3
  pulse_needs_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> $past(selQ));
  // R10
  pulse_mapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> (int'(wrAddr) < DEPTH));
endmodule

bind hostMuxBus hostMuxBusChk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .adOe(adOe), .wrPulse(wrPulse),
  .wrAddr(wrAddr), .selQ(selQ), .asS(asS)
);

// File: tb/sim_hostMuxBus.sv
`timescale 1ns/1ps
module sim_hostMuxBus;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] adIn = '0;
  logic asIn = 1'b1, dsIn = 1'b1, rwIn = 1'b1, csN = 1'b1;
  logic [7:0] adOut, wrAddr, wrData;
  logic adOe, wrPulse;

  int checks = 0, errors = 0, pulses = 0;
  logic [7:0] lastAddr, lastData;
  logic [7:0] model [8];
  bit doneFlag = 0;

  hostMuxBus #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .asIn(asIn), .dsIn(dsIn), .rwIn(rwIn), .csN(csN),
    .wrPulse(wrPulse), .wrAddr(wrAddr), .wrData(wrData)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rstN && wrPulse) begin
    pulses++;
    lastAddr = wrAddr;
    lastData = wrData;
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRead(int a);
    return (a < DEPTH) ? int'(model[a]) : 0;
  endfunction

  task automatic finish();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // address phase then address-strobe fall
  task automatic startAcc(logic [7:0] a, logic cs, bit styleA);
    asIn = 1'b1; wt(6);
    adIn = a; csN = cs; dsIn = styleA; rwIn = 1'b1; wt(6);
    asIn = 1'b0; wt(6);
  endtask

  task automatic readA(string req, int expOe, int expVal);
    dsIn = 1'b0; wt(6);
    chk(req, adOe, expOe);
    if (expOe != 0) chk(req, adOut, expVal);
    dsIn = 1'b1; wt(6);
    chk(req, adOe, 0);
  endtask

  task automatic readB(string req, int expOe, int expVal);
    rwIn = 1'b1; dsIn = 1'b1; wt(6);
    chk(req, adOe, expOe);
    if (expOe != 0) chk(req, adOut, expVal);
    dsIn = 1'b0; wt(6);
    chk(req, adOe, 0);
  endtask

  task automatic writeA(logic [7:0] d);
    adIn = d; wt(2); rwIn = 1'b0; wt(6); rwIn = 1'b1; wt(6);
  endtask

  task automatic writeB(logic [7:0] d);
    adIn = d; rwIn = 1'b0; wt(2); dsIn = 1'b1; wt(6); dsIn = 1'b0; wt(6);
    rwIn = 1'b1; wt(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    int p0;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) model[i] = '0;
    wt(4);
    // R1 reset state
    chk("R1 oe", adOe, 0);
    chk("R1 pulse", wrPulse, 0);
    rstN = 1'b1; wt(4);
    startAcc(8'd2, 1'b0, 1);
    readA("R1 reg zero", 1, 0);

    // R5 style A write, R2 address capture
    p0 = pulses;
    startAcc(8'd1, 1'b0, 1);
    writeA(8'hA5); model[1] = 8'hA5;
    chk("R5 pulse", pulses - p0, 1);
    chk("R5 data", lastData, 8'hA5);
    chk("R2 addr", lastAddr, 1);

    // R4 style A read back
    startAcc(8'd1, 1'b0, 1);
    readA("R4", 1, 8'hA5);

    // R7 style B write, R11 style switch
    p0 = pulses;
    startAcc(8'd3, 1'b0, 0);
    writeB(8'h3C); model[3] = 8'h3C;
    chk("R7 pulse", pulses - p0, 1);
    chk("R7 data", lastData, 8'h3C);
    // R6 style B read
    startAcc(8'd3, 1'b0, 0);
    readB("R6", 1, 8'h3C);
    startAcc(8'd1, 1'b0, 1);
    readA("R11 back to A", 1, 8'hA5);

    // R8 second strobe in the same access ignored
    p0 = pulses;
    startAcc(8'd0, 1'b0, 1);
    writeA(8'h11); writeA(8'h22); model[0] = 8'h11;
    chk("R8 one pulse", pulses - p0, 1);
    startAcc(8'd0, 1'b0, 1);
    readA("R8 first value kept", 1, 8'h11);

    // R3 deselected access
    p0 = pulses;
    startAcc(8'd0, 1'b1, 0);
    writeB(8'h77);
    chk("R3 no pulse", pulses - p0, 0);
    readB("R3 no oe", 0, 0);
    startAcc(8'd0, 1'b0, 1);
    readA("R3 reg unchanged", 1, 8'h11);

    // R9 address phase with read-like strobes
    asIn = 1'b1; wt(6);
    csN = 1'b0; dsIn = 1'b0; rwIn = 1'b1; adIn = 8'd1;
    wt(3); chk("R9 addr phase", adOe, 0);
    wt(5); chk("R9 addr phase", adOe, 0);

    // R10 unmapped write and read
    p0 = pulses;
    startAcc(8'd6, 1'b0, 0);
    writeB(8'h99);
    chk("R10 no pulse", pulses - p0, 0);
    readB("R10 read zero", 1, 0);

    // random accesses
    for (int k = 0; k < 60; k++) begin
      automatic int a = $urandom_range(7);
      automatic bit sel = ($urandom_range(3) != 0);
      automatic bit stA = $urandom_range(1);
      automatic bit wr = $urandom_range(1);
      automatic logic [7:0] d = 8'($urandom);
      p0 = pulses;
      startAcc(8'(a), ~sel, stA);
      if (wr) begin
        if (stA) writeA(d); else writeB(d);
        chk("R11 rnd pulse", pulses - p0, (sel && a < DEPTH) ? 1 : 0);
        if (sel && a < DEPTH) begin
          model[a] = d;
          chk("R2 rnd addr", lastAddr, a);
        end
      end else begin
        if (stA) readA("R11 rnd readA", sel, expRead(a));
        else readB("R11 rnd readB", sel, expRead(a));
      end
    end
    asIn = 1'b1; wt(6);
    finish();
  end
endmodule